// File: doc/BRIEF.md
# Tone Generator and Modulation Selector

This block produces the digital square tone for a supply-line signalling path and chooses what drives the tone line. The tone is the free-running converter clock divided by twenty, so a clock near 440 kHz gives a tone near 22 kHz at an even 50% duty. Two control bits pick one of three sources: a continuous tone, the internal tone gated by an envelope input, or an already modulated tone taken from an external input and passed straight through.

The external input goes through a two-stage synchronizer before use. In envelope mode the gate only opens or closes at a tone-cycle boundary, so the line never carries a shortened pulse. In pass-through mode a hangover timer of one tone period restarts on each synchronized rising edge and returns the line to idle once edges stop. A separate output picks the high (transmit) or low (receive) threshold for an external tone detector.

Top module: `tone_mod_sel`

## Requirements
- R1: The internal tone has a period of DIV clocks (default 20): after reset release, with n rising clock edges seen since release, the internal tone is 1 when (n mod 20) < 10 and 0 otherwise.
- R2: While rst_n is low, and just after release with tone_en = 0, tone_out and tone_active are 0.
- R3: With tone_en = 1, tone_out follows the internal tone and tone_active is 1, whatever mod_sel and mod_pin are.
- R4: With tone_en = 0 and mod_sel = 0, tone_out is the internal tone ANDed with a gate; the gate takes the value mod_pin had two edges earlier, and changes only on the edge that ends a tone period (the edge where n mod 20 goes from 19 to 0).
- R5: In envelope mode every high pulse on tone_out lasts exactly 10 clocks.
- R6: With tone_en = 0 and mod_sel = 1, tone_out equals mod_pin delayed by two clock edges while the hangover window is open, and 0 otherwise.
- R7: The hangover window opens on the edge where the two-edge-delayed mod_pin rises and stays open for that cycle and the next 20 cycles; a new rising edge restarts it. In pass-through mode tone_active shows the window.
- R8: thr_hi is the OR of tx_pin and thr_bit; 1 selects the transmit threshold, 0 the receive threshold.
- R9: In envelope mode tone_active equals the gate of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, twenty times the tone rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_en | input | 1 | Continuous tone request bit |
| mod_sel | input | 1 | Source select: 0 envelope, 1 external tone |
| mod_pin | input | 1 | External envelope or modulated tone input |
| tx_pin | input | 1 | Transmit indication input |
| thr_bit | input | 1 | Threshold register bit |
| tone_out | output | 1 | Digital tone drive |
| tone_active | output | 1 | Tone source currently on |
| thr_hi | output | 1 | Detector threshold select, 1 = transmit |

## Verification
Two functions can act on the same edge: an envelope change reaching the end of the two-stage synchronizer exactly on the tone-period wrap edge, and a fresh rising edge on the external input landing in the cycle the hangover window would close. Both are provoked by driving mod_pin with pseudo-random hold lengths from 1 to 48 clocks in every mode for several hundred cycles, so the arrival point sweeps across all twenty phases and all window ages. Each cycle is judged against an edge-count model in the bench, and pulse widths in envelope mode are measured directly.

// File: rtl/tone_pkg.sv
package tone_pkg;

  typedef enum logic [1:0] {
    SRC_CONT = 2'd0,
    SRC_ENV  = 2'd1,
    SRC_EXT  = 2'd2
  } tone_src_e;

  // Source decode: enable wins over select.
  function automatic tone_src_e pick_src(input logic en, input logic sel);
    if (en)       return SRC_CONT;
    else if (sel) return SRC_EXT;
    else          return SRC_ENV;
  endfunction

  // High for the first half of the period.
  function automatic logic tone_level(input int unsigned ph, input int unsigned div);
    return ph < (div / 2);
  endfunction

  function automatic int unsigned next_phase(input int unsigned ph, input int unsigned div);
    return (ph == div - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/tone_div.sv
module tone_div #(
  parameter int DIV = 20,
  parameter int CW  = $clog2(DIV)
) (
  input  logic clk,
  input  logic rst_n,
  output logic tone_sq,
  output logic wrap
);
  import tone_pkg::*;

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= CW'(next_phase(int'(phase), DIV));
  end

  assign wrap    = (int'(phase) == DIV - 1);
  assign tone_sq = tone_level(int'(phase), DIV);

  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (phase == '0));
  p_rise_at_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_sq) |-> (phase == '0));
endmodule

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tone_env_gate.sv
module tone_env_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic env,
  output logic gate_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate_q <= 1'b0;
    else if (wrap) gate_q <= env;
  end

  p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(gate_q));
  p_gate_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (gate_q == $past(env)));
endmodule

// File: rtl/tone_hangover.sv
module tone_hangover #(
  parameter int HANG = 20,
  parameter int HW   = $clog2(HANG + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic active
);
  logic          sig_d;
  logic          rise;
  logic [HW-1:0] left;

  assign rise = sig && !sig_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_d <= 1'b0;
      left  <= '0;
    end else begin
      sig_d <= sig;
      if (rise)             left <= HW'(HANG);
      else if (left != '0)  left <= left - 1'b1;
    end
  end

  assign active = rise || (left != '0);

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (left == HW'(HANG)));
  p_stay_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (left == '0 && !rise) |=> (left == '0));
endmodule

// File: rtl/tone_mod_sel.sv
module tone_mod_sel #(
  parameter int DIV         = 20,
  parameter int SYNC_STAGES = 2,
  parameter int HANG        = DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_en,
  input  logic mod_sel,
  input  logic mod_pin,
  input  logic tx_pin,
  input  logic thr_bit,
  output logic tone_out,
  output logic tone_active,
  output logic thr_hi
);
  import tone_pkg::*;

  logic      tone_sq;
  logic      wrap;
  logic      mod_s;
  logic      gate_q;
  logic      hang_on;
  tone_src_e src;

  tone_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tone_sq(tone_sq), .wrap(wrap)
  );

  tone_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mod_pin), .q(mod_s)
  );

  tone_env_gate u_gate (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .env(mod_s), .gate_q(gate_q)
  );

  tone_hangover #(.HANG(HANG)) u_hang (
    .clk(clk), .rst_n(rst_n), .sig(mod_s), .active(hang_on)
  );

  assign src = pick_src(tone_en, mod_sel);

  always_comb begin
    unique case (src)
      SRC_CONT: begin tone_out = tone_sq;            tone_active = 1'b1;    end
      SRC_EXT:  begin tone_out = mod_s && hang_on;   tone_active = hang_on; end
      default:  begin tone_out = tone_sq && gate_q;  tone_active = gate_q;  end
    endcase
  end

  assign thr_hi = tx_pin | thr_bit;

  p_ext_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EXT && !hang_on) |-> !tone_out);
  p_cont_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tone_en |-> tone_active);
  p_env_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_ENV && $rose(tone_out)) |-> $past(wrap));
endmodule

// File: tb/tb_tone_mod_sel.sv
module tb_tone_mod_sel;
  localparam int CLK_P = 10;
  localparam int PER   = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tone_en = 1'b0, mod_sel = 1'b0, mod_pin = 1'b0, tx_pin = 1'b0, thr_bit = 1'b0;
  logic tone_out, tone_active, thr_hi;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  tone_mod_sel dut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .mod_sel(mod_sel),
    .mod_pin(mod_pin), .tx_pin(tx_pin), .thr_bit(thr_bit),
    .tone_out(tone_out), .tone_active(tone_active), .thr_hi(thr_hi)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // bench model state
  int n = 0;
  logic m1 = 0, m2 = 0, gate_m = 0;
  int age = 1000;
  logic [15:0] lfsr = 16'hACE1;
  int hold = 1;
  int run = 0;

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic model_edge();
    logic old2;
    logic boundary;
    boundary = ((n % PER) == PER - 1);
    old2 = m2;
    if (boundary) gate_m = m2;
    m2 = m1;
    m1 = mod_pin;
    n++;
    if (m2 && !old2) age = 0;
    else if (age < 1000) age++;
  endtask

  task automatic run_phase(input logic en, input logic sel, input int cycles);
    logic was;
    tone_en = en; mod_sel = sel;
    run = 0;
    was = tone_out;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      begin
        logic t, win, eo, ea;
        string tag;
        t   = ((n % PER) < PER/2);
        win = (age <= PER);
        if (en)       begin eo = t;        ea = 1'b1;  tag = "R3"; end
        else if (sel) begin eo = m2 & win; ea = win;   tag = "R6"; end
        else          begin eo = t & gate_m; ea = gate_m; tag = "R4"; end
        chk(tag, tone_out, eo);
        chk(en ? "R3" : (sel ? "R7" : "R9"), tone_active, ea);
        chk("R8", thr_hi, tx_pin | thr_bit);
        if (!en && !sel) begin
          if (tone_out) run++;
          else begin
            if (was && c > 0 && run > 0) chk("R5", run, PER/2);
            run = 0;
          end
        end
        was = tone_out;
      end
      // next stimulus
      lfsr = step(lfsr);
      tx_pin = lfsr[3];
      thr_bit = lfsr[7];
      hold--;
      if (hold <= 0) begin
        mod_pin = ~mod_pin;
        hold = 1 + int'(lfsr[15:8]) % 48;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2", tone_out, 0);
    chk("R2", tone_active, 0);
    rst_n = 1'b1;
    @(negedge clk);
    n = 0;
    // still before any edge? one edge happened since release at negedge
    n = 1;
    chk("R2", tone_out, 0);
    chk("R2", tone_active, 0);

    // R1: continuous tone period check, mod_pin held steady
    tone_en = 1'b1;
    begin
      int hi = 0;
      for (int c = 0; c < 2*PER; c++) begin
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R1", tone_out, ((n % PER) < PER/2));
        if (tone_out) hi++;
      end
      chk("R1", hi, PER);
    end

    run_phase(1'b0, 1'b0, 900);
    run_phase(1'b0, 1'b1, 900);
    run_phase(1'b1, 1'b1, 300);
    run_phase(1'b1, 1'b0, 300);
    run_phase(1'b0, 1'b0, 700);
    run_phase(1'b0, 1'b1, 700);

    // R7: hold mod_pin high long; window must close after 20 cycles
    tone_en = 0; mod_sel = 1; mod_pin = 0;
    for (int c = 0; c < 30; c++) begin
      @(posedge clk); model_edge(); @(negedge clk);
    end
    mod_pin = 1;
    for (int c = 0; c < 40; c++) begin
      @(posedge clk); model_edge(); @(negedge clk);
      chk("R7", tone_active, (c >= 1 && c <= 21));
      chk("R6", tone_out, (c >= 1 && c <= 21));
    end

    // R2: reset again
    rst_n = 1'b0; tone_en = 0; mod_sel = 0;
    @(negedge clk);
    chk("R2", tone_out, 0);
    chk("R2", tone_active, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule